// File: doc/BRIEF.md
# DMA Descriptor Fetch Sequencer

This block turns a peripheral interrupt into a set of decoded DMA transfer parameters. Each interrupt line owns a slot in a vector table, given as a flat input port. The slot holds the byte address of a packed descriptor in RAM. The sequencer accepts the request, then reads the descriptor one 16-bit word at a time over a request/grant memory port. It stores each word in the parameter register that the word's position in the layout selects, and it pulses a valid strobe to the transfer engine once the last needed word has arrived.

The mode word decides the layout. It comes first and enables up to three optional fields: an operation address for calculation transfers, a 32-bit chain address and a 32-bit end-of-transfer handler address. A field that is not enabled takes no space, so every later field moves up by its size. A multiple-transfer layout replaces the single source/destination pair with up to seven consecutive pairs. If the chain option is set, the chain address becomes the base of the next descriptor, and that descriptor is fetched right after the current one. Requests that arrive during a fetch are queued and served afterwards.

Top module: `dma_desc_seq`

## Requirements
- R1: After reset, `busy`, `p_valid`, `p_err` and `mem_req` are low and every parameter output is zero.
- R2: A pending request is served from the base address in its slot of `vec_table` (slot i at bits i*AW and up). The lowest-numbered pending line goes first, and `p_irq` reports the line being served.
- R3: Descriptor words are read at consecutive byte addresses base, base+2, base+4 and so on, with one read outstanding at a time. `mem_req` and `mem_addr` hold until `mem_gnt`, and the word is taken from `mem_rdata` one cycle after the grant.
- R4: Mode bits: bit 0 is calculation, bit 1 is chain, bit 2 is end interrupt, bit 3 is multiple transfer, and bits 6:4 give the pair count. In the single-pair layout the word order is mode, count, source, operation address (only if bit 0 is set), destination. With bit 0 clear, the destination is at base+6.
- R5: The chain address (low word, then high word, only if bit 1 is set) and then the handler address (low word, then high word, only if bit 2 is set) follow the body with no gap. Fields that are not enabled are not read and read as zero on the outputs.
- R6: With bit 3 set, count is followed by N source/destination word pairs. N is bits 6:4, with 0 read as 1 and values above the pair limit (7) held at the limit. Bit 0 is ignored, so the operation output stays zero. Unused pairs read zero.
- R7: `p_valid` pulses for one cycle, in the second cycle after the grant of the last word. `busy` is high from the cycle after acceptance up to the valid pulse, and low during it.
- R8: If the mode word implies a descriptor longer than 32 bytes, `p_err` pulses once, no further word is read, and no valid pulse or chain follows.
- R9: When bit 1 is set, the descriptor at `{chain high, chain low}` is fetched next, before any queued request, under the same `p_irq`.
- R10: A request that arrives while a fetch is in progress is held and served after the current descriptor completes.
- R11: The parameter outputs keep their values from the valid pulse until the next descriptor is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NIRQ | One-cycle request pulse per interrupt line |
| vec_table | input | NIRQ*AW | Descriptor base address per interrupt line |
| mem_req | output | 1 | Read request to RAM |
| mem_addr | output | AW | Byte address of the requested word |
| mem_gnt | input | 1 | Grant for the current request |
| mem_rdata | input | 16 | Read data, valid one cycle after grant |
| busy | output | 1 | Descriptor fetch in progress |
| p_valid | output | 1 | One-cycle pulse: parameters complete |
| p_err | output | 1 | One-cycle pulse: descriptor too long |
| p_irq | output | IW | Interrupt line of the current descriptor |
| p_mode | output | 16 | Mode word |
| p_count | output | 16 | Transfer count |
| p_oper | output | 16 | Operation address |
| p_src | output | PAIR_MAX*16 | Source words, pair k at bits 16k and up |
| p_dst | output | PAIR_MAX*16 | Destination words, pair k at bits 16k and up |
| p_chain | output | 32 | Chain address |
| p_iadr | output | 32 | End-of-transfer handler address |

## Verification
A wrong word counter or a wrong base shows on `mem_addr` at the very next grant. A wrong field pointer does not show until the valid pulse, where a value lands in the wrong parameter output or a skipped field reads nonzero. A wrong length decode changes the number of reads and moves the valid pulse, or raises a false error pulse one cycle after the mode word arrives. A lost or stale pending bit shows only later, as a missing, repeated or reordered descriptor fetch, so the queued-request cases check the order of `p_irq` across several descriptors.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;

    localparam int WORD_W   = 16;
    localparam int MB_CALC  = 0;
    localparam int MB_CHAIN = 1;
    localparam int MB_IRQ   = 2;
    localparam int MB_MULTI = 3;
    localparam int MB_NLO   = 4;
    localparam int MB_NHI   = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT
    } seq_state_e;

    typedef enum logic [3:0] {
        F_MODE,
        F_COUNT,
        F_SRC,
        F_OPER,
        F_DST,
        F_CHAIN_LO,
        F_CHAIN_HI,
        F_IADR_LO,
        F_IADR_HI,
        F_END
    } field_e;

endpackage

// File: rtl/dma_desc_pick.sv
module dma_desc_pick #(
    parameter int NIRQ = 4,
    localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic [NIRQ-1:0] pend_i,
    output logic            any_o,
    output logic [IW-1:0]   idx_o
);
    always_comb begin
        any_o = |pend_i;
        idx_o = '0;
        for (int i = NIRQ - 1; i >= 0; i--) begin
            if (pend_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/dma_desc_len.sv
module dma_desc_len
    import dma_desc_pkg::*;
#(
    parameter int PAIR_MAX  = 7,
    parameter int MAX_BYTES = 32,
    localparam int PW = $clog2(PAIR_MAX + 1)
) (
    input  logic [MB_NHI:0] mode_i,
    output logic [PW-1:0]   npairs_o,
    output logic            err_o
);
    logic [2:0] raw;
    logic [7:0] body_len;
    logic [7:0] total_len;

    always_comb begin
        raw = mode_i[MB_NHI:MB_NLO];
        if (raw == 3'd0)               npairs_o = PW'(1);
        else if (int'(raw) > PAIR_MAX) npairs_o = PW'(PAIR_MAX);
        else                           npairs_o = PW'(raw);

        body_len = mode_i[MB_MULTI] ? (8'd4 + (8'(npairs_o) << 2))
                                    : (8'd8 + (mode_i[MB_CALC] ? 8'd2 : 8'd0));
        total_len = body_len + (mode_i[MB_CHAIN] ? 8'd4 : 8'd0)
                             + (mode_i[MB_IRQ]   ? 8'd4 : 8'd0);
        err_o = total_len > 8'(MAX_BYTES);
    end
endmodule

// File: rtl/dma_desc_step.sv
module dma_desc_step
    import dma_desc_pkg::*;
#(
    parameter int PAIR_MAX = 7,
    localparam int PW = $clog2(PAIR_MAX + 1)
) (
    input  field_e          fld_i,
    input  logic [PW-1:0]   pair_i,
    input  logic [PW-1:0]   npairs_i,
    input  logic [MB_MULTI:0] mode_i,
    output field_e          fld_o,
    output logic [PW-1:0]   pair_o
);
    field_e tail;
    logic [PW:0] pair_inc;

    always_comb begin
        pair_o   = pair_i;
        pair_inc = {1'b0, pair_i} + (PW+1)'(1);
        tail     = mode_i[MB_CHAIN] ? F_CHAIN_LO :
                   mode_i[MB_IRQ]   ? F_IADR_LO  : F_END;
        case (fld_i)
            F_MODE:  fld_o = F_COUNT;
            F_COUNT: begin
                fld_o  = F_SRC;
                pair_o = '0;
            end
            F_SRC:   fld_o = (!mode_i[MB_MULTI] && mode_i[MB_CALC]) ? F_OPER : F_DST;
            F_OPER:  fld_o = F_DST;
            F_DST: begin
                if (mode_i[MB_MULTI] && (pair_inc < {1'b0, npairs_i})) begin
                    fld_o  = F_SRC;
                    pair_o = pair_i + PW'(1);
                end else begin
                    fld_o = tail;
                end
            end
            F_CHAIN_LO: fld_o = F_CHAIN_HI;
            F_CHAIN_HI: fld_o = mode_i[MB_IRQ] ? F_IADR_LO : F_END;
            F_IADR_LO:  fld_o = F_IADR_HI;
            default:    fld_o = F_END;
        endcase
    end
endmodule

// File: rtl/dma_desc_seq.sv
module dma_desc_seq
    import dma_desc_pkg::*;
#(
    parameter int NIRQ      = 4,
    parameter int AW        = 32,
    parameter int PAIR_MAX  = 7,
    parameter int MAX_BYTES = 32,
    localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1,
    localparam int PW = $clog2(PAIR_MAX + 1),
    localparam int XW = $clog2(MAX_BYTES / 2 + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NIRQ-1:0]          irq_req,
    input  logic [NIRQ*AW-1:0]       vec_table,
    output logic                     mem_req,
    output logic [AW-1:0]            mem_addr,
    input  logic                     mem_gnt,
    input  logic [WORD_W-1:0]        mem_rdata,
    output logic                     busy,
    output logic                     p_valid,
    output logic                     p_err,
    output logic [IW-1:0]            p_irq,
    output logic [WORD_W-1:0]        p_mode,
    output logic [WORD_W-1:0]        p_count,
    output logic [WORD_W-1:0]        p_oper,
    output logic [PAIR_MAX*WORD_W-1:0] p_src,
    output logic [PAIR_MAX*WORD_W-1:0] p_dst,
    output logic [2*WORD_W-1:0]      p_chain,
    output logic [2*WORD_W-1:0]      p_iadr
);

    typedef struct packed {
        seq_state_e                        st;
        logic [AW-1:0]                     base;
        logic [XW-1:0]                     widx;
        field_e                            fld;
        logic [PW-1:0]                     pair;
        logic [NIRQ-1:0]                   pend;
        logic                              chain_go;
        logic [IW-1:0]                     irq;
        logic                              busy;
        logic                              valid;
        logic                              err;
        logic [WORD_W-1:0]                 mode;
        logic [WORD_W-1:0]                 count;
        logic [WORD_W-1:0]                 oper;
        logic [PAIR_MAX-1:0][WORD_W-1:0]   src;
        logic [PAIR_MAX-1:0][WORD_W-1:0]   dst;
        logic [2*WORD_W-1:0]               chain;
        logic [2*WORD_W-1:0]               iadr;
    } seq_t;

    seq_t s_d, s_q;

    logic              pick_any;
    logic [IW-1:0]     pick_idx;
    logic [WORD_W-1:0] mode_cur;
    logic [PW-1:0]     npairs;
    logic              len_err;
    field_e            step_fld;
    logic [PW-1:0]     step_pair;

    // the mode word decides the layout while it is still on the bus
    assign mode_cur = (s_q.fld == F_MODE) ? mem_rdata : s_q.mode;

    dma_desc_pick #(.NIRQ(NIRQ)) u_pick (
        .pend_i (s_q.pend),
        .any_o  (pick_any),
        .idx_o  (pick_idx)
    );

    dma_desc_len #(.PAIR_MAX(PAIR_MAX), .MAX_BYTES(MAX_BYTES)) u_len (
        .mode_i   (mode_cur[MB_NHI:0]),
        .npairs_o (npairs),
        .err_o    (len_err)
    );

    dma_desc_step #(.PAIR_MAX(PAIR_MAX)) u_step (
        .fld_i    (s_q.fld),
        .pair_i   (s_q.pair),
        .npairs_i (npairs),
        .mode_i   (mode_cur[MB_MULTI:0]),
        .fld_o    (step_fld),
        .pair_o   (step_pair)
    );

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        s_d.err   = 1'b0;
        s_d.pend  = s_q.pend | irq_req;
        case (s_q.st)
            ST_IDLE: begin
                if (s_q.chain_go || pick_any) begin
                    s_d.st    = ST_FETCH;
                    s_d.busy  = 1'b1;
                    s_d.widx  = '0;
                    s_d.fld   = F_MODE;
                    s_d.pair  = '0;
                    s_d.mode  = '0;
                    s_d.count = '0;
                    s_d.oper  = '0;
                    s_d.src   = '0;
                    s_d.dst   = '0;
                    s_d.chain = '0;
                    s_d.iadr  = '0;
                    if (s_q.chain_go) begin
                        s_d.chain_go = 1'b0;
                        s_d.base     = AW'(s_q.chain);
                    end else begin
                        s_d.base           = vec_table[pick_idx*AW +: AW];
                        s_d.irq            = pick_idx;
                        s_d.pend[pick_idx] = irq_req[pick_idx];
                    end
                end
            end
            ST_FETCH: begin
                if (mem_gnt) s_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                case (s_q.fld)
                    F_MODE:     s_d.mode              = mem_rdata;
                    F_COUNT:    s_d.count             = mem_rdata;
                    F_SRC:      s_d.src[s_q.pair]     = mem_rdata;
                    F_OPER:     s_d.oper              = mem_rdata;
                    F_DST:      s_d.dst[s_q.pair]     = mem_rdata;
                    F_CHAIN_LO: s_d.chain[WORD_W-1:0] = mem_rdata;
                    F_CHAIN_HI: s_d.chain[2*WORD_W-1:WORD_W] = mem_rdata;
                    F_IADR_LO:  s_d.iadr[WORD_W-1:0]  = mem_rdata;
                    F_IADR_HI:  s_d.iadr[2*WORD_W-1:WORD_W]  = mem_rdata;
                    default:    ;
                endcase
                s_d.widx = s_q.widx + XW'(1);
                s_d.fld  = step_fld;
                s_d.pair = step_pair;
                if (s_q.fld == F_MODE && len_err) begin
                    s_d.st   = ST_IDLE;
                    s_d.busy = 1'b0;
                    s_d.err  = 1'b1;
                end else if (step_fld == F_END) begin
                    s_d.st       = ST_IDLE;
                    s_d.busy     = 1'b0;
                    s_d.valid    = 1'b1;
                    s_d.chain_go = mode_cur[MB_CHAIN];
                end else begin
                    s_d.st = ST_FETCH;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mem_req  = (s_q.st == ST_FETCH);
    assign mem_addr = s_q.base + AW'({s_q.widx, 1'b0});
    assign busy     = s_q.busy;
    assign p_valid  = s_q.valid;
    assign p_err    = s_q.err;
    assign p_irq    = s_q.irq;
    assign p_mode   = s_q.mode;
    assign p_count  = s_q.count;
    assign p_oper   = s_q.oper;
    assign p_src    = s_q.src;
    assign p_dst    = s_q.dst;
    assign p_chain  = s_q.chain;
    assign p_iadr   = s_q.iadr;

    // R3: a request waiting for grant keeps its address
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    // R3: one read in flight
    p_one_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt) |=> !mem_req);

    // R7: reads only while busy
    p_req_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R7: valid pulse ends the busy window and never meets an error
    p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        p_valid |-> (!busy && !p_err));

    // R8: an error stops the fetch
    p_err_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        p_err |-> (!busy && !mem_req));

    // R11: outputs frozen while idle
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> ($stable(p_count) && $stable(p_src) && $stable(p_iadr)));

    // R2: the chosen line is really pending
    p_pick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pick_any |-> s_q.pend[pick_idx]);

endmodule

// File: tb/dma_desc_seq_test.sv
`timescale 1ns/1ps
module dma_desc_seq_test;
    localparam int NIRQ = 4;
    localparam int AW   = 32;
    localparam int NP   = 7;
    localparam logic [31:0] CH_BASE = 32'h100;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NIRQ-1:0]   irq_req = '0;
    logic [NIRQ*AW-1:0] vec = '0;
    logic              mem_req, mem_gnt = 1'b0;
    logic [AW-1:0]     mem_addr;
    logic [15:0]       mem_rdata = '0;
    logic              busy, p_valid, p_err;
    logic [1:0]        p_irq;
    logic [15:0]       p_mode, p_count, p_oper;
    logic [NP*16-1:0]  p_src, p_dst;
    logic [31:0]       p_chain, p_iadr;

    logic [15:0] mem [0:255];
    logic [31:0] log_a [0:4095];
    int log_n = 0;
    int checks = 0, errors = 0;
    int gcyc = 0;
    int since = 100;

    always #2 clk = ~clk;

    dma_desc_seq #(.NIRQ(NIRQ), .AW(AW), .PAIR_MAX(NP), .MAX_BYTES(32)) uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .vec_table(vec),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .busy(busy), .p_valid(p_valid), .p_err(p_err), .p_irq(p_irq),
        .p_mode(p_mode), .p_count(p_count), .p_oper(p_oper),
        .p_src(p_src), .p_dst(p_dst), .p_chain(p_chain), .p_iadr(p_iadr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // grant pattern with stalls
    always @(negedge clk) begin
        gcyc++;
        mem_gnt <= (gcyc % 3) != 1;
    end

    // RAM model and read log
    always @(posedge clk) begin
        if (rst_n) begin
            if (p_valid) chk("R7 valid two cycles after last grant", 32'(since), 32'd1);
            if (mem_req && mem_gnt) begin
                mem_rdata <= mem[mem_addr[8:1]];
                log_a[log_n] = mem_addr;
                log_n++;
                since = 0;
            end else begin
                since++;
            end
        end
    end

    function automatic logic [15:0] fv(input logic [31:0] a);
        return a[15:0] ^ 16'h5A3C;
    endfunction
    function automatic int npr(input logic [15:0] m);
        int r = int'(m[6:4]);
        return (r == 0) ? 1 : r;
    endfunction
    function automatic int offch(input logic [15:0] m);
        return m[3] ? 2 + 2 * npr(m) : 4 + int'(m[0]);
    endfunction
    function automatic int nwd(input logic [15:0] m);
        return offch(m) + (m[1] ? 2 : 0) + (m[2] ? 2 : 0);
    endfunction
    function automatic logic [15:0] w(input logic [31:0] base, input int k);
        return mem[8'(base[8:1] + 8'(k))];
    endfunction

    task automatic build(input logic [31:0] base, input logic [15:0] m);
        for (int k = 0; k < 16; k++) mem[8'(base[8:1] + 8'(k))] = fv(base + 32'(2 * k));
        mem[base[8:1]] = m;
        if (m[1] && nwd(m) <= 16) begin
            mem[8'(base[8:1] + 8'(offch(m)))]     = CH_BASE[15:0];
            mem[8'(base[8:1] + 8'(offch(m) + 1))] = CH_BASE[31:16];
        end
    endtask

    task automatic wait_done(output bit got_v, output bit got_e);
        int t = 0;
        got_v = 0; got_e = 0;
        while (!p_valid && !p_err && t < 400) begin
            @(negedge clk);
            t++;
        end
        got_v = p_valid;
        got_e = p_err;
        if (!got_v && !got_e) chk("R7 timeout waiting for completion", 32'd0, 32'd1);
    endtask

    task automatic expect_desc(input logic [31:0] base, input logic [15:0] m,
                               input int start, input int irq);
        int oc, oi, n, bad;
        logic [15:0] es, ed;
        chk("R4 mode word", 32'(p_mode), 32'(m));
        chk("R4 count", 32'(p_count), 32'(w(base, 1)));
        chk("R7 busy low at valid", 32'(busy), 32'd0);
        chk("R2 irq reported", 32'(p_irq), 32'(irq));
        if (!m[3]) begin
            chk("R4 source", 32'(p_src[15:0]), 32'(w(base, 2)));
            chk("R4 operation address", 32'(p_oper), m[0] ? 32'(w(base, 3)) : 32'd0);
            chk("R4 destination", 32'(p_dst[15:0]), 32'(w(base, 3 + int'(m[0]))));
            chk("R5 unused pairs zero", 32'((|p_src[NP*16-1:16]) | (|p_dst[NP*16-1:16])), 32'd0);
        end else begin
            n = npr(m);
            bad = 0;
            for (int k = 0; k < NP; k++) begin
                es = (k < n) ? w(base, 2 + 2 * k) : 16'd0;
                ed = (k < n) ? w(base, 3 + 2 * k) : 16'd0;
                if (p_src[k*16 +: 16] !== es || p_dst[k*16 +: 16] !== ed) bad++;
            end
            chk("R6 pair words", 32'(bad), 32'd0);
            chk("R6 operation ignored", 32'(p_oper), 32'd0);
        end
        oc = offch(m);
        oi = oc + (m[1] ? 2 : 0);
        chk("R5 chain field", p_chain, m[1] ? {w(base, oc + 1), w(base, oc)} : 32'd0);
        chk("R5 handler field", p_iadr, m[2] ? {w(base, oi + 1), w(base, oi)} : 32'd0);
        chk("R3 read count", 32'(log_n - start), 32'(nwd(m)));
        bad = 0;
        for (int k = 0; k < nwd(m); k++)
            if (log_a[start + k] !== base + 32'(2 * k)) bad++;
        chk("R3 read addresses consecutive", 32'(bad), 32'd0);
    endtask

    task automatic run(input logic [31:0] base, input int irq, input logic [15:0] m);
        bit gv, ge, experr;
        int start;
        logic [15:0] cnt_seen;
        experr = nwd(m) > 16;
        if (m[1]) build(CH_BASE, 16'h0000);
        build(base, m);
        vec[irq*AW +: AW] = base;
        start = log_n;
        @(negedge clk) irq_req = NIRQ'(1 << irq);
        @(negedge clk) irq_req = '0;
        @(negedge clk);
        chk("R7 busy after acceptance", 32'(busy), 32'd1);
        wait_done(gv, ge);
        if (experr) begin
            chk("R8 error pulse", 32'(ge), 32'd1);
            chk("R8 no valid on error", 32'(gv), 32'd0);
            chk("R8 single read", 32'(log_n - start), 32'd1);
            repeat (4) @(negedge clk);
            chk("R8 no chain after error", 32'(log_n - start), 32'd1);
        end else begin
            chk("R7 valid pulse", 32'(gv), 32'd1);
            expect_desc(base, m, start, irq);
            if (m[1]) begin
                start = log_n;
                @(negedge clk);
                wait_done(gv, ge);
                chk("R9 chained descriptor valid", 32'(gv), 32'd1);
                expect_desc(CH_BASE, 16'h0000, start, irq);
            end
            cnt_seen = p_count;
            repeat (4) @(negedge clk);
            chk("R11 count held after valid", 32'(p_count), 32'(cnt_seen));
            chk("R7 single valid pulse", 32'(p_valid), 32'd0);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        bit gv, ge;
        int sa, sb, sc;
        for (int k = 0; k < 256; k++) mem[k] = 16'h0;
        repeat (4) @(negedge clk);
        chk("R1 busy at reset", 32'(busy), 32'd0);
        chk("R1 request at reset", 32'(mem_req), 32'd0);
        chk("R1 valid and error at reset", 32'({p_valid, p_err}), 32'd0);
        chk("R1 outputs at reset", 32'(p_count | p_mode | p_chain[15:0]), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // single-pair layouts: every option combination
        for (int m = 0; m < 8; m++) begin
            logic [31:0] b;
            b = 32'h20 + 32'(m % 4) * 32'h40;
            run(b, m % NIRQ, 16'(m));
        end

        // multi-pair layouts: all pair counts with chain/handler options
        for (int n = 0; n < 8; n++) begin
            for (int o = 0; o < 4; o++) begin
                logic [15:0] m;
                m = 16'h8 | 16'(n << 4) | 16'(o << 1) | 16'(n & 1);
                run(32'h40, (n + o) % NIRQ, m);
            end
        end

        // queued requests and priority (R10, R2)
        build(32'h40, 16'h0000);
        build(32'h80, 16'h0000);
        build(32'hC0, 16'h0004);
        vec[2*AW +: AW] = 32'h40;
        vec[1*AW +: AW] = 32'h80;
        vec[3*AW +: AW] = 32'hC0;
        sa = log_n;
        @(negedge clk) irq_req = 4'b0100;
        @(negedge clk) irq_req = 4'b0000;
        repeat (3) @(negedge clk);
        irq_req = 4'b1010;
        @(negedge clk) irq_req = 4'b0000;
        wait_done(gv, ge);
        chk("R10 first descriptor valid", 32'(gv), 32'd1);
        expect_desc(32'h40, 16'h0000, sa, 2);
        sb = log_n;
        @(negedge clk);
        wait_done(gv, ge);
        chk("R10 queued lower line served next", 32'(gv), 32'd1);
        expect_desc(32'h80, 16'h0000, sb, 1);
        sc = log_n;
        @(negedge clk);
        wait_done(gv, ge);
        chk("R10 queued higher line served last", 32'(gv), 32'd1);
        expect_desc(32'hC0, 16'h0004, sc, 3);
        repeat (6) @(negedge clk);
        chk("R10 no extra fetch", 32'(log_n - sc), 32'd6);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule